// File: doc/BRIEF.md
# Register Aperture Bridge for Legacy Display Ports

The bridge decodes a 4 KiB register aperture behind a plain request/response bus. Three sub-windows sit in the aperture. The first is a bank of byte-wide legacy display ports. The second is an indexed file of 16-bit extension registers. The third is a small control area that reports its own size and holds the framebuffer byte-order mode. Every other offset is unmapped.

The bridge adapts access widths and sequences accesses. A 16-bit write into the legacy bank becomes two byte writes, low byte first. An index port is therefore set before its companion data port. A 16-bit legacy read merges two adjacent ports. An extension access first loads the index register and then reads or writes the data at that index. The byte-order mode changes only when one of two magic words is written. Both register files are held inside the block as simple arrays. Legacy writes are also presented on an output port, so the order of the byte writes can be observed.

Top module: `mwb_bridge`

## Requirements
- R1: A byte access (req_size_i = 0; 1 = 16-bit, 2 = 32-bit) at aperture offset 0x400+n, with n in 0..0x1F, reaches legacy port 0x3C0+n. A byte read returns the port value in bits 7:0 and zero above.
- R2: A 16-bit write at 0x400+n, with n ≤ 0x1E, issues two writes on the legacy write port in consecutive cycles: the low byte to 0x3C0+n, then the high byte to 0x3C0+n+1. req_ready_o is low for exactly the first of these two cycles.
- R3: A 16-bit read at 0x400+n returns port n in bits 7:0 and port n+1 in bits 15:8.
- R4: A 16-bit access at an even offset 0x500+2k, with k in 0..10, loads the index register (ext_index_o) with k in the next cycle. It then reads or writes the 16-bit extension register k.
- R5: A 32-bit read at 0x600 returns 8. A write there changes nothing.
- R6: A 32-bit access at 0x604 is the byte-order register. It reads 0xBEBEBEBE when big_endian_o is 1 and 0x1E1E1E1E when it is 0. Writing 0xBEBEBEBE sets the mode. Writing 0x1E1E1E1E clears it. Any other value leaves it unchanged.
- R7: When ext_en_i is 0, the whole 0x600 range is unmapped and revision_o is 1. When ext_en_i is 1, revision_o is 2.
- R8: Unmapped offsets are treated as unmapped. So are accesses of a disallowed size or alignment: a legacy access that is neither byte nor 16-bit, or a 16-bit one at n = 0x1F; an extension access that is not 16-bit at an even offset; a control access that is not 32-bit at 0 or 4. An unmapped read returns 0 and an unmapped write has no effect. Such an access is accepted at once.
- R9: After reset, big_endian_o is 0, ext_index_o is 0, req_ready_o is 1 and rsp_valid_o is 0.
- R10: Each accepted request yields exactly one rsp_valid_o pulse, in the cycle after acceptance, in request order. The read data of a write response is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_en_i | input | 1 | Enables the control sub-window |
| req_valid_i | input | 1 | Request valid, held until accepted |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 12 | Aperture byte offset |
| req_size_i | input | 2 | 0 byte, 1 16-bit, 2 32-bit |
| req_wdata_i | input | 32 | Write data, least significant bytes used |
| req_ready_o | output | 1 | Request accepted when high together with valid |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_rdata_o | output | 32 | Read data |
| leg_wr_valid_o | output | 1 | Legacy port write strobe |
| leg_wr_port_o | output | 10 | Legacy port number |
| leg_wr_data_o | output | 8 | Legacy port write byte |
| ext_index_o | output | 4 | Extension index register |
| big_endian_o | output | 1 | Framebuffer byte-order mode |
| revision_o | output | 8 | Revision code |

## Verification
Two events can share a cycle. One is the response of an access. The other is the acceptance of the next access, or the first byte of a split write. The bench drives every access back to back with no idle cycle, including a 16-bit legacy read straight after a split write to the same ports. A scoreboard queue is checked in order against each response pulse. A second queue holds the expected legacy port writes. It flags any write that is missing, extra or out of order, and any response that arrives with nothing pending.

// File: rtl/mwb_pkg.sv
package mwb_pkg;
  localparam int unsigned ADDR_W    = 12;
  localparam int unsigned LEG_SPAN  = 32;
  localparam int unsigned LEG_AW    = $clog2(LEG_SPAN);
  localparam int unsigned EXT_REGS  = 11;
  localparam int unsigned EXT_IW    = $clog2(EXT_REGS);
  localparam int unsigned CTL_SPAN  = 8;
  localparam logic [ADDR_W-1:0] LEG_BASE = 12'h400;
  localparam logic [ADDR_W-1:0] EXT_BASE = 12'h500;
  localparam logic [ADDR_W-1:0] CTL_BASE = 12'h600;
  localparam logic [9:0]  LEG_PORT_BASE  = 10'h3C0;
  localparam logic [31:0] BO_BIG         = 32'hBEBE_BEBE;
  localparam logic [31:0] BO_LITTLE      = 32'h1E1E_1E1E;

  typedef enum logic [1:0] {SZ_B = 2'd0, SZ_H = 2'd1, SZ_W = 2'd2} size_e;
  typedef enum logic [1:0] {RG_NONE, RG_LEG, RG_EXT, RG_CTL} region_e;
endpackage

// File: rtl/mwb_decode.sv
module mwb_decode import mwb_pkg::*; (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic              ext_en_i,
  output region_e           region_o,
  output logic [LEG_AW-1:0] leg_off_o,
  output logic [EXT_IW-1:0] ext_idx_o,
  output logic              ctl_bo_o
);
  logic [ADDR_W-1:0] leg_rel, ext_rel, ctl_rel;
  logic leg_in, ext_in, ctl_in, leg_ok, ext_ok, ctl_ok;

  assign leg_rel = addr_i - LEG_BASE;
  assign ext_rel = addr_i - EXT_BASE;
  assign ctl_rel = addr_i - CTL_BASE;

  assign leg_in = (addr_i >= LEG_BASE) && (leg_rel < ADDR_W'(LEG_SPAN));
  assign ext_in = (addr_i >= EXT_BASE) && (ext_rel < ADDR_W'(2 * EXT_REGS));
  assign ctl_in = (addr_i >= CTL_BASE) && (ctl_rel < ADDR_W'(CTL_SPAN));

  // 16-bit legacy access must keep its high byte inside the bank
  assign leg_ok = (size_i == SZ_B) ||
                  ((size_i == SZ_H) && (leg_rel < ADDR_W'(LEG_SPAN - 1)));
  assign ext_ok = (size_i == SZ_H) && !ext_rel[0];
  assign ctl_ok = ext_en_i && (size_i == SZ_W) && (ctl_rel[1:0] == 2'b00);

  always_comb begin
    region_o = RG_NONE;
    if (leg_in && leg_ok)      region_o = RG_LEG;
    else if (ext_in && ext_ok) region_o = RG_EXT;
    else if (ctl_in && ctl_ok) region_o = RG_CTL;
  end

  assign leg_off_o = leg_rel[LEG_AW-1:0];
  assign ext_idx_o = ext_rel[EXT_IW:1];
  assign ctl_bo_o  = ctl_rel[2];
endmodule

// File: rtl/mwb_legacy_file.sv
module mwb_legacy_file #(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_off_i,
  input  logic [7:0]    wr_data_i,
  input  logic [AW-1:0] rd_off_i,
  output logic [7:0]    rd_lo_o,
  output logic [7:0]    rd_hi_o
);
  logic [7:0] port_q [DEPTH];
  logic [AW-1:0] rd_off_hi;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) port_q[i] <= '0;
    end else if (wr_en_i) begin
      port_q[wr_off_i] <= wr_data_i;
    end
  end

  assign rd_off_hi = rd_off_i + AW'(1);
  assign rd_lo_o   = port_q[rd_off_i];
  assign rd_hi_o   = port_q[rd_off_hi];
endmodule

// File: rtl/mwb_ext_file.sv
module mwb_ext_file #(
  parameter int unsigned REGS = 11,
  localparam int unsigned IW  = $clog2(REGS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          acc_i,
  input  logic          wr_i,
  input  logic [IW-1:0] idx_i,
  input  logic [15:0]   wdata_i,
  output logic [15:0]   rdata_o,
  output logic [IW-1:0] idx_o
);
  logic [15:0]   reg_q [REGS];
  logic [IW-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      for (int i = 0; i < REGS; i++) reg_q[i] <= '0;
    end else if (acc_i) begin
      idx_q <= idx_i;
      if (wr_i && (idx_i < IW'(REGS))) reg_q[idx_i] <= wdata_i;
    end
  end

  assign rdata_o = (idx_i < IW'(REGS)) ? reg_q[idx_i] : 16'h0;
  assign idx_o   = idx_q;

  a_r4_index_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i |=> (idx_o == $past(idx_i)));
endmodule

// File: rtl/mwb_bridge.sv
module mwb_bridge import mwb_pkg::*; #(
  parameter int unsigned CTL_SIZE_VAL = CTL_SPAN,
  parameter logic [7:0]  REV_BASE     = 8'd1,
  parameter logic [7:0]  REV_EXT      = 8'd2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_en_i,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_size_i,
  input  logic [31:0]       req_wdata_i,
  output logic              req_ready_o,
  output logic              rsp_valid_o,
  output logic [31:0]       rsp_rdata_o,
  output logic              leg_wr_valid_o,
  output logic [9:0]        leg_wr_port_o,
  output logic [7:0]        leg_wr_data_o,
  output logic [EXT_IW-1:0] ext_index_o,
  output logic              big_endian_o,
  output logic [7:0]        revision_o
);
  typedef enum logic {ST_IDLE, ST_SPLIT} st_e;

  region_e           region;
  logic [LEG_AW-1:0] leg_off, lw_off, hi_off_q;
  logic [EXT_IW-1:0] ext_idx;
  logic              ctl_bo;
  st_e               st_q;
  logic [7:0]        hi_data_q, lw_data, leg_lo, leg_hi;
  logic              idle_req, split_go, accept, lw_en, bo_wr, be_q;
  logic [15:0]       ext_rdata;
  logic [31:0]       rd_mux;
  logic              rsp_valid_q;
  logic [31:0]       rsp_rdata_q;

  mwb_decode u_dec (
    .addr_i(req_addr_i), .size_i(req_size_i), .ext_en_i(ext_en_i),
    .region_o(region), .leg_off_o(leg_off), .ext_idx_o(ext_idx), .ctl_bo_o(ctl_bo)
  );

  assign idle_req    = (st_q == ST_IDLE) && req_valid_i;
  assign split_go    = idle_req && req_write_i && (region == RG_LEG) && (req_size_i == SZ_H);
  assign req_ready_o = (st_q == ST_SPLIT) || !split_go;
  assign accept      = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      hi_off_q  <= '0;
      hi_data_q <= '0;
    end else if (split_go) begin
      st_q      <= ST_SPLIT;
      hi_off_q  <= leg_off + LEG_AW'(1);
      hi_data_q <= req_wdata_i[15:8];
    end else begin
      st_q      <= ST_IDLE;
    end
  end

  // legacy write port: low byte in the idle cycle, high byte in the split cycle
  always_comb begin
    lw_en   = 1'b0;
    lw_off  = leg_off;
    lw_data = req_wdata_i[7:0];
    if (st_q == ST_SPLIT) begin
      lw_en   = 1'b1;
      lw_off  = hi_off_q;
      lw_data = hi_data_q;
    end else if (idle_req && req_write_i && (region == RG_LEG)) begin
      lw_en   = 1'b1;
    end
  end

  mwb_legacy_file #(.DEPTH(LEG_SPAN)) u_leg (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(lw_en), .wr_off_i(lw_off),
    .wr_data_i(lw_data), .rd_off_i(leg_off), .rd_lo_o(leg_lo), .rd_hi_o(leg_hi)
  );

  mwb_ext_file #(.REGS(EXT_REGS)) u_ext (
    .clk_i(clk_i), .rst_ni(rst_ni), .acc_i(idle_req && (region == RG_EXT)),
    .wr_i(req_write_i), .idx_i(ext_idx), .wdata_i(req_wdata_i[15:0]),
    .rdata_o(ext_rdata), .idx_o(ext_index_o)
  );

  assign bo_wr = idle_req && req_write_i && (region == RG_CTL) && ctl_bo;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  be_q <= 1'b0;
    else if (bo_wr && req_wdata_i == BO_BIG)      be_q <= 1'b1;
    else if (bo_wr && req_wdata_i == BO_LITTLE)   be_q <= 1'b0;
  end

  always_comb begin
    rd_mux = '0;
    unique case (region)
      RG_LEG:  rd_mux = (req_size_i == SZ_H) ? {16'h0, leg_hi, leg_lo} : {24'h0, leg_lo};
      RG_EXT:  rd_mux = {16'h0, ext_rdata};
      RG_CTL:  rd_mux = ctl_bo ? (be_q ? BO_BIG : BO_LITTLE) : 32'(CTL_SIZE_VAL);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= accept;
      rsp_rdata_q <= (accept && !req_write_i) ? rd_mux : 32'h0;
    end
  end

  assign rsp_valid_o    = rsp_valid_q;
  assign rsp_rdata_o    = rsp_rdata_q;
  assign leg_wr_valid_o = lw_en;
  assign leg_wr_port_o  = LEG_PORT_BASE + 10'(lw_off);
  assign leg_wr_data_o  = lw_data;
  assign big_endian_o   = be_q;
  assign revision_o     = ext_en_i ? REV_EXT : REV_BASE;

  a_r2_hi_follows_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SPLIT) |-> (lw_en && lw_off == $past(lw_off) + LEG_AW'(1)));
  a_r2_stall_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ready_o |=> req_ready_o);
  a_r6_mode_needs_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (big_endian_o != $past(big_endian_o)) |-> $past(bo_wr));
  a_r8_unmapped_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && $past(region == RG_NONE)) |-> (rsp_rdata_o == 32'h0));
  a_r10_rsp_follows_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> rsp_valid_o);
endmodule

// File: tb/sim_mwb_bridge.sv
`timescale 1ns/1ps
module sim_mwb_bridge;
  logic clk = 1'b0, rst_n = 1'b0, ext_en = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, leg_wr_valid, big_endian;
  logic [31:0] rsp_rdata;
  logic [9:0]  leg_wr_port;
  logic [7:0]  leg_wr_data, revision;
  logic [3:0]  ext_index;

  int checks = 0, errors = 0, last_stall = 0;
  logic [31:0] rsp_q [$];
  string       tag_q [$];
  logic [17:0] leg_q [$];

  always #4 clk = ~clk;

  mwb_bridge u0 (
    .clk_i(clk), .rst_ni(rst_n), .ext_en_i(ext_en), .req_valid_i(req_valid),
    .req_write_i(req_write), .req_addr_i(req_addr), .req_size_i(req_size),
    .req_wdata_i(req_wdata), .req_ready_o(req_ready), .rsp_valid_o(rsp_valid),
    .rsp_rdata_o(rsp_rdata), .leg_wr_valid_o(leg_wr_valid), .leg_wr_port_o(leg_wr_port),
    .leg_wr_data_o(leg_wr_data), .ext_index_o(ext_index), .big_endian_o(big_endian),
    .revision_o(revision)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver: called at a negedge, returns at the negedge after acceptance
  task automatic access(input bit wr, input logic [11:0] addr, input logic [1:0] size,
                        input logic [31:0] wdata, input logic [31:0] exp, input string tag);
    rsp_q.push_back(wr ? 32'h0 : exp);
    tag_q.push_back(tag);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_size = size; req_wdata = wdata;
    last_stall = 0;
    #1;
    while (!req_ready) begin
      last_stall++;
      @(negedge clk); #1;
    end
    @(negedge clk);
  endtask

  task automatic idle();
    req_valid = 1'b0;
    @(negedge clk);
  endtask

  // monitor: compares responses and legacy writes as they appear
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (rsp_valid) begin
        if (rsp_q.size() == 0) check(1'b0, "R10 unexpected response", rsp_rdata, 32'h0);
        else begin
          logic [31:0] e;
          string t;
          e = rsp_q.pop_front();
          t = tag_q.pop_front();
          check(rsp_rdata == e, t, rsp_rdata, e);
        end
      end
      if (leg_wr_valid) begin
        if (leg_q.size() == 0) check(1'b0, "R8 unexpected legacy write", {14'h0, leg_wr_port, leg_wr_data}, 32'h0);
        else begin
          logic [17:0] l;
          l = leg_q.pop_front();
          check({leg_wr_port, leg_wr_data} == l, "R2 legacy write order", {14'h0, leg_wr_port, leg_wr_data}, {14'h0, l});
        end
      end
    end
  end

  initial begin
    #800000;
    check(1'b0, "watchdog expired", 32'h0, 32'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(req_ready == 1'b1, "R9 ready after reset", {31'h0, req_ready}, 32'h1);
    check(rsp_valid == 1'b0, "R9 no response in reset", {31'h0, rsp_valid}, 32'h0);
    check(big_endian == 1'b0, "R9 little-endian after reset", {31'h0, big_endian}, 32'h0);
    check(ext_index == 4'h0, "R9 index cleared", {28'h0, ext_index}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(revision == 8'd2, "R7 revision enabled", {24'h0, revision}, 32'd2);

    // R1 byte path
    leg_q.push_back({10'h3C4, 8'h11});
    access(1'b1, 12'h404, 2'd0, 32'hFFFF_FF11, 0, "R1 byte write");
    access(1'b0, 12'h404, 2'd0, 0, 32'h11, "R1 byte read");
    // R2 split write, then R3 merged read back to back
    leg_q.push_back({10'h3D4, 8'h5A});
    leg_q.push_back({10'h3D5, 8'hA5});
    access(1'b1, 12'h414, 2'd1, 32'h0000_A55A, 0, "R2 split write");
    check(last_stall == 1, "R2 ready low one cycle", last_stall, 1);
    access(1'b0, 12'h414, 2'd1, 0, 32'hA55A, "R3 merged read");
    check(last_stall == 0, "R2 no stall on read", last_stall, 0);
    access(1'b0, 12'h415, 2'd0, 0, 32'hA5, "R3 high port byte");
    access(1'b0, 12'h413, 2'd1, 0, 32'h5A00, "R3 unaligned merge");
    // R8 illegal legacy shapes
    access(1'b1, 12'h41F, 2'd1, 32'h0000_7777, 0, "R8 split past bank");
    access(1'b1, 12'h408, 2'd2, 32'h1234_5678, 0, "R8 word to legacy");
    access(1'b0, 12'h41F, 2'd0, 0, 32'h0, "R8 last port untouched");
    access(1'b0, 12'h408, 2'd0, 0, 32'h0, "R8 word write ignored");
    // R4 extension file
    access(1'b1, 12'h50A, 2'd1, 32'h0000_1234, 0, "R4 ext write k5");
    check(ext_index == 4'd5, "R4 index after write", {28'h0, ext_index}, 32'd5);
    access(1'b1, 12'h514, 2'd1, 32'h0000_BEEF, 0, "R4 ext write k10");
    check(ext_index == 4'd10, "R4 index k10", {28'h0, ext_index}, 32'd10);
    access(1'b0, 12'h50A, 2'd1, 0, 32'h1234, "R4 ext read k5");
    check(ext_index == 4'd5, "R4 index after read", {28'h0, ext_index}, 32'd5);
    access(1'b0, 12'h514, 2'd1, 0, 32'hBEEF, "R4 ext read k10");
    access(1'b0, 12'h50A, 2'd0, 0, 32'h0, "R8 ext byte read");
    access(1'b1, 12'h50B, 2'd1, 32'h0000_9999, 0, "R8 ext odd write");
    access(1'b0, 12'h516, 2'd1, 0, 32'h0, "R8 ext past end");
    check(ext_index == 4'd10, "R8 index kept on illegal", {28'h0, ext_index}, 32'd10);
    access(1'b0, 12'h50A, 2'd1, 0, 32'h1234, "R8 ext odd write ignored");
    // R5 and R6 control area
    access(1'b0, 12'h600, 2'd2, 0, 32'd8, "R5 size read");
    access(1'b1, 12'h600, 2'd2, 32'hFFFF_FFFF, 0, "R5 size write");
    access(1'b0, 12'h600, 2'd2, 0, 32'd8, "R5 size unchanged");
    access(1'b0, 12'h604, 2'd2, 0, 32'h1E1E_1E1E, "R6 little read");
    access(1'b1, 12'h604, 2'd2, 32'hBEBE_BEBE, 0, "R6 set big");
    check(big_endian == 1'b1, "R6 big set", {31'h0, big_endian}, 32'h1);
    access(1'b1, 12'h604, 2'd2, 32'h1234_5678, 0, "R6 bad value");
    check(big_endian == 1'b1, "R6 bad value ignored", {31'h0, big_endian}, 32'h1);
    access(1'b0, 12'h604, 2'd2, 0, 32'hBEBE_BEBE, "R6 big read");
    access(1'b0, 12'h604, 2'd1, 0, 32'h0, "R8 half read of control");
    // R7 control area disabled
    idle();
    ext_en = 1'b0;
    #1;
    check(revision == 8'd1, "R7 revision disabled", {24'h0, revision}, 32'd1);
    access(1'b1, 12'h604, 2'd2, 32'h1E1E_1E1E, 0, "R7 write while disabled");
    check(big_endian == 1'b1, "R7 mode kept while disabled", {31'h0, big_endian}, 32'h1);
    access(1'b0, 12'h600, 2'd2, 0, 32'h0, "R7 size hidden");
    access(1'b0, 12'h604, 2'd2, 0, 32'h0, "R7 order hidden");
    idle();
    ext_en = 1'b1;
    access(1'b1, 12'h604, 2'd2, 32'h1E1E_1E1E, 0, "R6 clear big");
    check(big_endian == 1'b0, "R6 big cleared", {31'h0, big_endian}, 32'h0);
    // R8 unmapped offsets
    access(1'b0, 12'h000, 2'd2, 0, 32'h0, "R8 low hole");
    access(1'b0, 12'h700, 2'd0, 0, 32'h0, "R8 high hole");
    access(1'b1, 12'hFFF, 2'd0, 32'hFF, 0, "R8 write hole");
    idle();
    idle();
    check(rsp_q.size() == 0, "R10 all responses seen", rsp_q.size(), 0);
    check(leg_q.size() == 0, "R2 all legacy writes seen", leg_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule